// File: doc/BRIEF.md
# Multiphase PWM Power-State Sequencer

This block drives up to four interleaved pulse-width-modulated phase outputs from one shared period counter. A two-bit power-state input selects the output shape. In the full-power state every phase runs, and each phase's carrier is shifted by an equal fraction of the period. In the three reduced states only one phase switches. Every other phase is parked at a mid (tri-state) drive code rather than pulled low.

Each phase output is a two-bit drive code, and a downstream driver stage decodes it. The duty value comes from a register and is compared against each phase carrier. A new power state, and the phase-select bit used in the single-phase continuous state, are taken in only at a period boundary, so a state change never cuts a pulse short. A discontinuous-mode flag follows the applied state for logic further down the chain.

Top module: `phase_pwm_sequencer`

## Requirements
- R1: Each phase drive code is 2'b00 for low, 2'b01 for high or 2'b10 for mid. The code 2'b11 never appears.
- R2: A single 8-bit period counter counts up by one every cycle and wraps from 255 to 0. While reset is held, the counter is 0, the applied state is full power and the stored phase select is 0.
- R3: In applied state 2'b00 (full power), phase k (k = 0..3) drives high when (count + 64*k) mod 256 is below the duty value, and low otherwise. No phase is mid.
- R4: In applied state 2'b01 (single phase, continuous), only one phase switches. That phase is phase 0 when the stored select bit is 0 and phase 2 when it is 1, and it keeps its own carrier offset. All other phases are mid.
- R5: In applied states 2'b10 and 2'b11 (single phase, discontinuous), only phase 0 switches and phases 1 to 3 are mid.
- R6: dcmMode is 1 exactly when the applied state is 2'b10 or 2'b11.
- R7: The power-state and phase-select inputs are captured only at the clock edge where the counter reads 255. They take effect in the cycle where it reads 0, and a change at any other time has no effect on the outputs until then.
- R8: The duty value is compared combinationally, so it affects outputs in the same cycle. A duty of 0 keeps every active phase low, and a duty of 255 keeps it high in all cycles but one per period.

Top module port list:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| powerState | input | 2 | Requested power state |
| ps1UseThird | input | 1 | Selects phase 2 instead of phase 0 in the single-phase continuous state |
| duty | input | 8 | Duty threshold compared with each carrier |
| phaseOut | output | 8 | Two-bit drive code per phase; phase k occupies bits 2k+1:2k |
| dcmMode | output | 1 | High in the discontinuous single-phase states |

## Verification
The phase codes are combinational in the counter, the applied state and the duty input. A duty change therefore shows in the same cycle, and each counter step shows one cycle after the rising edge that made it. A power-state or select change is due at the first cycle with count 0 after the edge at count 255, which can be up to 256 cycles after the input moved. The bench drives inputs one time unit after a rising edge and advances a behavioural model at each rising edge. It compares every phase code and the flag against that model at each falling edge, so each result is read in the cycle it is due.

// File: rtl/pwm_seq_pkg.sv
package pwm_seq_pkg;

  typedef enum logic [1:0] {
    PS_FULL     = 2'b00,
    PS_ONE_CCM  = 2'b01,
    PS_ONE_DCM  = 2'b10,
    PS_SLEEP    = 2'b11
  } pwrState_e;

  typedef enum logic [1:0] {
    DRV_LOW  = 2'b00,
    DRV_HIGH = 2'b01,
    DRV_MID  = 2'b10
  } drive_e;

  // strobes from control to datapath
  typedef struct packed {
    logic singleMode;  // only one phase switches
    logic useAlt;      // active phase is the half-period one
  } phaseCtl_t;

endpackage

// File: rtl/pwm_seq_ctrl.sv
module pwm_seq_ctrl
  import pwm_seq_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [1:0]       powerState,
  input  logic             ps1UseThird,
  output logic [CNT_W-1:0] count,
  output pwrState_e        appliedState,
  output phaseCtl_t        ctl,
  output logic             dcmMode
);

  localparam logic [CNT_W-1:0] CNT_LAST = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] CNT_ONE  = {{(CNT_W-1){1'b0}}, 1'b1};

  logic periodLast;
  logic useAltQ;

  assign periodLast = (count == CNT_LAST);

  // period counter and boundary-aligned state capture
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count        <= '0;
      appliedState <= PS_FULL;
      useAltQ      <= 1'b0;
    end else begin
      count <= count + CNT_ONE;
      if (periodLast) begin
        appliedState <= pwrState_e'(powerState);
        useAltQ      <= ps1UseThird;
      end
    end
  end

  always_comb begin
    ctl.singleMode = (appliedState != PS_FULL);
    ctl.useAlt     = (appliedState == PS_ONE_CCM) && useAltQ;
    dcmMode        = (appliedState == PS_ONE_DCM) || (appliedState == PS_SLEEP);
  end

endmodule

// File: rtl/pwm_seq_datapath.sv
module pwm_seq_datapath
  import pwm_seq_pkg::*;
#(
  parameter int NUM_PHASES = 4,
  parameter int CNT_W      = 8
) (
  input  logic [CNT_W-1:0]        count,
  input  logic [CNT_W-1:0]        duty,
  input  phaseCtl_t               ctl,
  output logic [2*NUM_PHASES-1:0] phaseOut
);

  localparam int PERIOD  = 1 << CNT_W;
  localparam int STEP    = PERIOD / NUM_PHASES;
  localparam int ALT_IDX = NUM_PHASES / 2;

  for (genvar k = 0; k < NUM_PHASES; k++) begin : g_phase
    localparam logic [CNT_W-1:0] OFFS = CNT_W'(k * STEP);
    localparam bit IS_BASE = (k == 0);
    localparam bit IS_ALT  = (k == ALT_IDX);

    logic [CNT_W-1:0] carrier;
    logic             enabled;
    drive_e           code;

    assign carrier = count + OFFS;

    always_comb begin
      if (!ctl.singleMode) enabled = 1'b1;
      else if (ctl.useAlt) enabled = IS_ALT;
      else                 enabled = IS_BASE;

      if (!enabled)            code = DRV_MID;
      else if (carrier < duty) code = DRV_HIGH;
      else                     code = DRV_LOW;
    end

    assign phaseOut[2*k +: 2] = code;
  end

endmodule

// File: rtl/phase_pwm_sequencer.sv
module phase_pwm_sequencer
  import pwm_seq_pkg::*;
#(
  parameter int NUM_PHASES = 4,
  parameter int CNT_W      = 8
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [1:0]              powerState,
  input  logic                    ps1UseThird,
  input  logic [CNT_W-1:0]        duty,
  output logic [2*NUM_PHASES-1:0] phaseOut,
  output logic                    dcmMode
);

  logic [CNT_W-1:0] periodCount;
  pwrState_e        appliedState;
  phaseCtl_t        ctlBus;

  pwm_seq_ctrl #(.CNT_W(CNT_W)) i_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .powerState  (powerState),
    .ps1UseThird (ps1UseThird),
    .count       (periodCount),
    .appliedState(appliedState),
    .ctl         (ctlBus),
    .dcmMode     (dcmMode)
  );

  pwm_seq_datapath #(.NUM_PHASES(NUM_PHASES), .CNT_W(CNT_W)) i_dp (
    .count   (periodCount),
    .duty    (duty),
    .ctl     (ctlBus),
    .phaseOut(phaseOut)
  );

endmodule

// File: rtl/pwm_seq_checker.sv
module pwm_seq_checker
  import pwm_seq_pkg::*;
#(
  parameter int NUM_PHASES = 4,
  parameter int CNT_W      = 8
) (
  input logic                    clk,
  input logic                    rstN,
  input logic [2*NUM_PHASES-1:0] phaseOut,
  input logic                    dcmMode,
  input logic [CNT_W-1:0]        count,
  input pwrState_e               appliedState
);

  localparam logic [CNT_W-1:0] CNT_LAST = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] CNT_ONE  = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [NUM_PHASES-1:0] midMask;
  always_comb begin
    for (int k = 0; k < NUM_PHASES; k++) midMask[k] = (phaseOut[2*k +: 2] == DRV_MID);
  end

  for (genvar k = 0; k < NUM_PHASES; k++) begin : g_code
    // R1
    a_r1_code_legal: assert property (@(posedge clk) disable iff (!rstN)
      phaseOut[2*k +: 2] != 2'b11);
  end

  a_r2_count_step: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> count == $past(count) + CNT_ONE);

  a_r3_full_no_mid: assert property (@(posedge clk) disable iff (!rstN)
    appliedState == PS_FULL |-> midMask == '0);

  a_r4_ccm_one_active: assert property (@(posedge clk) disable iff (!rstN)
    appliedState == PS_ONE_CCM |-> $countones(midMask) == NUM_PHASES - 1);

  a_r5_dcm_phase0_only: assert property (@(posedge clk) disable iff (!rstN)
    dcmMode |-> (!midMask[0] && $countones(midMask) == NUM_PHASES - 1));

  a_r7_state_at_boundary: assert property (@(posedge clk) disable iff (!rstN)
    count != CNT_LAST |=> $stable(appliedState) && $stable(dcmMode));

endmodule

bind phase_pwm_sequencer pwm_seq_checker #(.NUM_PHASES(NUM_PHASES), .CNT_W(CNT_W)) i_chk (
  .clk         (clk),
  .rstN        (rstN),
  .phaseOut    (phaseOut),
  .dcmMode     (dcmMode),
  .count       (periodCount),
  .appliedState(appliedState)
);

// File: tb/test_phase_pwm_sequencer.sv
module test_phase_pwm_sequencer;

  localparam int CLK_PERIOD = 10;
  localparam int NPH = 4;

  logic       clk = 1'b0;
  logic       rstN;
  logic [1:0] powerState;
  logic       ps1UseThird;
  logic [7:0] duty;
  logic [7:0] phaseOut;
  logic       dcmMode;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // behavioural reference state
  int mCnt = 0;
  int mSt  = 0;
  int mSel = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  phase_pwm_sequencer i_phase_pwm_sequencer (
    .clk(clk), .rstN(rstN), .powerState(powerState), .ps1UseThird(ps1UseThird),
    .duty(duty), .phaseOut(phaseOut), .dcmMode(dcmMode)
  );

  always @(posedge clk) begin
    if (!rstN) begin
      mCnt = 0; mSt = 0; mSel = 0;
    end else begin
      if (mCnt == 255) begin
        mSt  = int'(powerState);
        mSel = int'(ps1UseThird);
      end
      mCnt = (mCnt + 1) % 256;
    end
  end

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d (cnt=%0d st=%0d)", tag, act, exp, mCnt, mSt);
    end
  endtask

  function automatic int expCode(int k);
    bit en;
    if (mSt == 0)      en = 1'b1;
    else if (mSt == 1) en = (k == (mSel != 0 ? 2 : 0));
    else               en = (k == 0);
    if (!en) return 2;
    return (((mCnt + 64 * k) % 256) < int'(duty)) ? 1 : 0;
  endfunction

  always @(negedge clk) begin
    if (!done) begin
      string tag;
      if (!rstN)        tag = "R2";
      else if (mSt == 0) tag = "R3";
      else if (mSt == 1) tag = "R4";
      else               tag = "R5";
      for (int k = 0; k < NPH; k++) begin
        check(tag, int'(phaseOut[2*k +: 2]), expCode(k));
        check("R1", int'(phaseOut[2*k +: 2] == 2'b11), 0);
      end
      check("R6", int'(dcmMode), int'(mSt >= 2));
      if (rstN && int'(powerState) != mSt) check("R7", int'(dcmMode), int'(mSt >= 2));
      if (rstN && (duty == 8'd0 || duty == 8'hFF)) check("R8", int'(phaseOut[1:0]), expCode(0));
    end
  end

  task automatic run(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin
    rstN = 1'b0; powerState = 2'b00; ps1UseThird = 1'b0; duty = 8'd100;
    run(5);
    rstN = 1'b1;
    run(600);
    duty = 8'd37;  run(130);
    powerState = 2'b01; run(400);              // continuous, phase 0
    ps1UseThird = 1'b1; run(77);               // mid-period select change
    duty = 8'd200; run(500);
    powerState = 2'b10; duty = 8'd0; run(600); // discontinuous, zero duty
    powerState = 2'b11; duty = 8'hFF; run(600);
    ps1UseThird = 1'b0; powerState = 2'b01; run(300);
    for (int i = 0; i < 20; i++) begin         // rapid mid-period toggling
      powerState = 2'(i % 4); ps1UseThird = i[1]; duty = 8'(i * 13);
      run(50);
    end
    powerState = 2'b00; duty = 8'd128; run(600);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule